// File: doc/BRIEF.md
# Program and Erase Status Readback

This block decides what byte a host sees when it reads a flash-style memory while an embedded write operation is running. A single-byte program or a whole-array erase is launched by a one-cycle start pulse; from then on an internal cycle counter keeps the block busy for a configurable number of clock cycles. The counter stands in for the real program and erase timers.

While busy, each read returns a status byte instead of array contents. Bit 7 is a polling bit: during a program it is the inverse of bit 7 of the byte being written, and during an erase it is 0, the inverse of the erased value. Bit 6 is a toggle bit that changes on every new read access. When the operation ends, reads return the true array byte on all eight bits and the toggle stops. A host can therefore detect completion either by waiting for bit 7 to match its data or by waiting for two reads in a row to agree on bit 6.

In the last busy cycle the block also gives the array the value to store. A program can only clear bits, so the stored value is the old byte ANDed with the new one. An erase stores all ones.

Top module: `pe_status_readback`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `commit_en` and `rd_byte` are all 0.
- R2: A program start makes `busy` high for exactly PROG_CYCLES clock cycles, starting in the cycle after the start pulse. An erase start does the same for ERASE_CYCLES cycles.
- R3: A start pulse that arrives while `busy` is high is ignored: the busy length, the polling bit and the committed byte stay those of the running operation. If both starts arrive together on an idle block, the erase wins.
- R4: A read captured while a program is busy returns bit 7 equal to the inverse of bit 7 of the loaded byte.
- R5: The first read captured after a start returns bit 6 = 0. Each later read captured while busy returns the opposite bit 6 of the read before it.
- R6: While busy, bits 5..0 of every read are 0. During an erase, bit 7 is also 0.
- R7: A read captured while not busy returns `array_byte` unchanged on all eight bits.
- R8: `commit_en` is high for exactly one cycle: the last busy cycle. During that cycle `commit_byte` equals `old_byte & load_byte` (sampled at start) for a program, or 8'hFF for an erase.
- R9: A read is captured only on a rising edge of `rd_stb` (high now, low in the previous cycle). Otherwise `rd_byte` holds its value, even while `rd_stb` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_start | input | 1 | One-cycle pulse that launches a byte program |
| erase_start | input | 1 | One-cycle pulse that launches an array erase |
| load_byte | input | 8 | Byte to be programmed, sampled with the start pulse |
| old_byte | input | 8 | Current array byte at the target, sampled with the start pulse |
| rd_stb | input | 1 | Read request; its rising edge captures one read |
| array_byte | input | 8 | True array data for the current read address |
| rd_byte | output | 8 | Registered read result |
| busy | output | 1 | An operation is running |
| commit_en | output | 1 | Write the committed byte into the array this cycle |
| commit_byte | output | 8 | Byte to be stored at the end of the operation |

## Verification
On every cycle, the assertions check the following:
- `commit_en` is always followed by `busy` falling.
- `busy` never drops before its final cycle.
- `rd_byte` holds between read edges.
- Each captured read has the right polling bit, the right zero bits, or the true data, depending on whether an operation is running.

The alternation of the toggle bit across a whole operation, its reset at each new start, and the exact busy length are shown only by the bench's sweeps. The same holds for ignored starts and for the merged byte over all 256 load values.

// File: rtl/pesr_pkg.sv
// Shared types and helpers for the program/erase status readback block.
// Assumes an 8-bit data path; the status layout puts polling on bit 7 and
// toggle on bit 6, which host software decodes.
package pesr_pkg;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_e;

    // Builds the status byte returned while an operation is running.
    function automatic logic [7:0] status_byte(op_e op, logic ld7, logic tog);
        logic poll;
        poll = (op == OP_ERASE) ? 1'b0 : ~ld7;
        return {poll, tog, 6'b000000};
    endfunction

endpackage

// File: rtl/pesr_op_timer.sv
// Operation timer: models the internal program and erase timers as a cycle
// counter. Assumes launch is only pulsed while not busy (the top gates it).
module pesr_op_timer #(
    parameter int PROG_CYCLES  = 3750,
    parameter int ERASE_CYCLES = 1250000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic is_erase,
    output logic busy,
    output logic last
);
    localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt;

    // Load the duration on launch and count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (launch) begin
            cnt <= is_erase ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Busy and final-cycle flags are decoded from the count.
    always_comb begin
        busy = (cnt != '0);
        last = (cnt == CNT_W'(1));
    end

    assert_end_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);

    assert_no_early_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);

endmodule

// File: rtl/pesr_toggle_track.sv
// Read-edge detector and toggle bit. The toggle returns to 0 on clear (an
// operation start) and flips on each rising edge of the read strobe.
module pesr_toggle_track (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic rd_stb,
    output logic rise,
    output logic tog
);
    logic rd_q;

    // Remember the strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_stb;
    end

    // A read access is a strobe that is high now and was low before.
    always_comb rise = rd_stb && !rd_q;

    // The toggle state restarts at 0 on clear and advances per access.
    always_ff @(posedge clk) begin
        if (!rst_n)     tog <= 1'b0;
        else if (clear) tog <= 1'b0;
        else if (rise)  tog <= ~tog;
    end

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !tog);

endmodule

// File: rtl/pe_status_readback.sv
// Top of the status readback block: it launches operations, latches their
// context, and chooses between the status byte and true array data on each
// read edge. Assumes array_byte is valid in the cycle of the read edge.
module pe_status_readback #(
    parameter int PROG_CYCLES  = 3750,
    parameter int ERASE_CYCLES = 1250000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_start,
    input  logic       erase_start,
    input  logic [7:0] load_byte,
    input  logic [7:0] old_byte,
    input  logic       rd_stb,
    input  logic [7:0] array_byte,
    output logic [7:0] rd_byte,
    output logic       busy,
    output logic       commit_en,
    output logic [7:0] commit_byte
);
    import pesr_pkg::*;

    logic       launch;
    logic       last;
    logic       rise;
    logic       tog;
    op_e        op_q;
    logic       ld7_q;
    logic [7:0] commit_q;

    // Starts are accepted only on an idle block.
    always_comb launch = !busy && (prog_start || erase_start);

    pesr_op_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .is_erase(erase_start),
        .busy    (busy),
        .last    (last)
    );

    pesr_toggle_track u_toggle (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .rd_stb(rd_stb),
        .rise  (rise),
        .tog   (tog)
    );

    // Latch the operation type, polling source and merged byte at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_PROG;
            ld7_q    <= 1'b0;
            commit_q <= 8'h00;
        end else if (launch) begin
            op_q     <= erase_start ? OP_ERASE : OP_PROG;
            ld7_q    <= load_byte[7];
            commit_q <= erase_start ? 8'hFF : (old_byte & load_byte);
        end
    end

    // Capture status or true data on each read edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    rd_byte <= 8'h00;
        else if (rise) rd_byte <= busy ? status_byte(op_q, ld7_q, tog) : array_byte;
    end

    // Drive the array write port in the final busy cycle.
    always_comb begin
        commit_en   = last;
        commit_byte = commit_q;
    end

    assert_idle_true_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !busy) |=> (rd_byte == $past(array_byte)));

    assert_prog_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && busy && op_q == OP_PROG) |=> (rd_byte[7] == ~ld7_q));

    assert_busy_zero_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && busy) |=> (rd_byte[5:0] == 6'b0 &&
                            (op_q == OP_PROG || rd_byte[7] == 1'b0)));

    assert_hold_between_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(rd_byte));

    assert_commit_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> busy);

endmodule

// File: tb/pe_status_readback_test.sv
module pe_status_readback_test;
    localparam int NP = 6;
    localparam int NE = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_start = 1'b0;
    logic       erase_start = 1'b0;
    logic [7:0] load_byte = 8'h00;
    logic [7:0] old_byte = 8'h00;
    logic       rd_stb = 1'b0;
    logic [7:0] array_byte = 8'h00;
    logic [7:0] rd_byte;
    logic       busy;
    logic       commit_en;
    logic [7:0] commit_byte;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pe_status_readback #(.PROG_CYCLES(NP), .ERASE_CYCLES(NE)) uut (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .erase_start(erase_start),
        .load_byte(load_byte), .old_byte(old_byte), .rd_stb(rd_stb),
        .array_byte(array_byte), .rd_byte(rd_byte), .busy(busy),
        .commit_en(commit_en), .commit_byte(commit_byte)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One full operation with alternating reads; optional ignored start at c==2.
    task automatic run_op(bit er, bit both, logic [7:0] ld, logic [7:0] old, bit inject);
        int n;
        logic [7:0] merged;
        logic [7:0] prev;
        logic [7:0] exp;
        bit tg;
        er = er | both;
        n = er ? NE : NP;
        merged = er ? 8'hFF : (old & ld);
        tg = 1'b0;
        array_byte = old;
        load_byte = ld; old_byte = old;
        prog_start = !er || both; erase_start = er;
        @(negedge clk);
        prog_start = 1'b0; erase_start = 1'b0;
        prev = rd_byte;
        for (int c = 1; c <= n + 4; c++) begin
            chk("R2 busy", {7'b0, busy}, {7'b0, (c <= n)});
            chk("R8 commit_en", {7'b0, commit_en}, {7'b0, (c == n)});
            if (c == n) chk("R8 commit_byte", commit_byte, merged);
            if (c % 2 == 0) begin
                if (c - 1 <= n) begin
                    exp = er ? {1'b0, tg, 6'b0} : {~ld[7], tg, 6'b0};
                    chk(er ? "R6 R5 erase status" : "R4 R5 prog status", rd_byte, exp);
                    tg = ~tg;
                end else begin
                    chk("R7 idle read", rd_byte, merged);
                end
            end else if (c > 1) begin
                chk("R9 hold", rd_byte, prev);
            end
            prev = rd_byte;
            if (c >= n) array_byte = merged;
            rd_stb = (c % 2 == 1);
            if (inject && c == 2) begin
                prog_start = 1'b1; erase_start = !er;
                load_byte = ~ld; old_byte = ~old;
            end else begin
                prog_start = 1'b0; erase_start = 1'b0;
            end
            @(negedge clk);
        end
        rd_stb = 1'b0; prog_start = 1'b0; erase_start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset rd_byte", rd_byte, 8'h00);
        chk("R1 reset busy", {7'b0, busy}, 8'h00);
        chk("R1 reset commit_en", {7'b0, commit_en}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: a held strobe captures only once.
        array_byte = 8'h5A; rd_stb = 1'b1;
        @(negedge clk);
        chk("R7 idle capture", rd_byte, 8'h5A);
        array_byte = 8'hC3;
        @(negedge clk);
        chk("R9 held strobe", rd_byte, 8'h5A);
        @(negedge clk);
        chk("R9 held strobe", rd_byte, 8'h5A);
        rd_stb = 1'b0;
        @(negedge clk);
        for (int v = 0; v < 256; v++) begin
            run_op(1'b0, 1'b0, 8'(v), 8'((v * 37 + 11) & 255), (v % 4 == 3));
        end
        for (int v = 0; v < 8; v++) begin
            run_op(1'b1, 1'b0, 8'(v * 29), 8'(v * 17), v[0]);
        end
        // R3: simultaneous starts, erase wins.
        run_op(1'b0, 1'b1, 8'h7E, 8'h81, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule